// File: doc/BRIEF.md
# Soft-Error Report Capture and Dual Readout

This block sits behind a configuration-memory integrity checker. Each time the checker finishes locating a corrupted frame, it presents a 46-bit error report with a one-cycle valid strobe. The block stores the report in a message register. It raises an error flag once that register holds the report, and it enforces a minimum quiet interval on the flag between reports. Two independent readers, a test-port path and a core-logic path, each receive a private snapshot of the report. Each path has an update register followed by a serial shift register, so either reader can unload a report at its own pace.

The block also produces the detection clock enable. This is a single-cycle pulse derived from the reference clock divided by a power of two, with the exponent latched at reset. Each reader owns a snapshot enable. While a reader holds its enable low, its snapshot is frozen, so a capture into the shift register can never race a new copy. A report that arrives during the freeze is copied as soon as the enable returns, and the event is remembered in a sticky overrun bit.

Top module: `seu_report_capture`

## Requirements
- R1: The message register loads `rpt_data` on every clock edge where `rpt_valid` is high, and the newest report always replaces the older one.
- R2: `err_flag` rises on the second clock edge after the edge that samples `rpt_valid`, that is, one edge after the message register has taken the report. The flag never rises without a new report since its previous rise.
- R3: `err_flag` stays high until the next `det_ce` pulse. After it falls it stays low for at least 32 `det_ce` pulses. After reset the flag is low.
- R4: A report that arrives while the flag is high or in its quiet interval is held pending. The flag then rises exactly once after the interval, and the message register holds the latest report.
- R5: When a path's `snap_en` bit is high, its update register copies the message register on the edge after the one that took the report.
- R6: While a path's `snap_en` bit is low, its update register keeps its value. A report that arrived meanwhile is copied on the first edge where `snap_en` is high again.
- R7: A path's `overrun` bit is set when a report is validated while that path's `snap_en` is low. It stays set until reset, and reset clears it.
- R8: A high `cap` bit parallel-loads the path's shift register from its update register. Capture takes priority over shift.
- R9: A high `shift` bit moves the shift register one place toward bit 0. `sout` always shows bit 0, so the report leaves LSB first, and `sin` enters at bit 45.
- R10: The two paths (bit 0 = test port, bit 1 = core logic) behave independently. Enable, capture, shift and overrun on one path never affect the other.
- R11: `det_ce` is a one-cycle pulse every 2^n clock cycles. n is `div_sel`, sampled only while reset is active. A value of 0 or above 8 is treated as 8, and changes made after reset have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_sel | input | 4 | Divider exponent n, sampled during reset |
| det_ce | output | 1 | Detection clock enable pulse |
| rpt_valid | input | 1 | Report valid strobe from the location search |
| rpt_data | input | 46 | Error report contents |
| err_flag | output | 1 | Error flag, rising edge marks a fresh report |
| snap_en | input | 2 | Per-path snapshot enable |
| cap | input | 2 | Per-path parallel capture into the shift register |
| shift | input | 2 | Per-path shift one bit toward LSB |
| sin | input | 2 | Per-path serial input into the MSB |
| sout | output | 2 | Per-path serial output (shift register bit 0) |
| overrun | output | 2 | Per-path sticky superseded-snapshot flag |

## Verification
A corrupted message register, update register or shift register shows up as wrong bits in the 46-bit serial unload. This is visible within 47 cycles of a capture. A flag state machine stuck in or skipping its quiet interval changes the measured number of `det_ce` pulses between a fall and the next rise, or produces an extra or missing rise within about a hundred cycles at the fastest divider setting. A wrong divider latch or clamp changes the measured distance between `det_ce` pulses on the very next period. A path enable or overrun leaking to the other path shows up as an old or new snapshot in the wrong reader's unload.

// File: rtl/seu_rpt_pkg.sv
package seu_rpt_pkg;

   typedef enum logic [1:0] {
      FL_IDLE = 2'd0,
      FL_HIGH = 2'd1,
      FL_QUIET = 2'd2
   } flag_state_t;

endpackage

// File: rtl/seu_det_ce_gen.sv
module seu_det_ce_gen #(
   parameter int SEL_W   = 4,
   parameter int EXP_MAX = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] div_sel,
   output logic             det_ce
);
   localparam int CNT_W = EXP_MAX;

   generate
      if (EXP_MAX < 1 || EXP_MAX >= (1 << SEL_W)) begin : g_bad_exp
         $error("seu_det_ce_gen: EXP_MAX must fit in SEL_W and be at least 1");
      end
   endgenerate

   logic [SEL_W-1:0] exp_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] limit;

   function automatic logic [SEL_W-1:0] clamp_exp(input logic [SEL_W-1:0] v);
      if (v == '0 || v > SEL_W'(EXP_MAX)) return SEL_W'(EXP_MAX);
      return v;
   endfunction

   // limit = 2^n - 1, built as a mask of n low ones
   always_comb begin
      for (int i = 0; i < CNT_W; i++) begin
         limit[i] = (SEL_W'(i) < exp_q);
      end
   end

   assign det_ce = (cnt_q == limit);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         exp_q <= clamp_exp(div_sel);
         cnt_q <= '0;
      end else begin
         cnt_q <= det_ce ? '0 : cnt_q + 1'b1;
      end
   end

   // R11: pulse is a single cycle wide for any legal exponent
   a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      det_ce |=> !det_ce);

   // R11: exponent frozen once out of reset
   a_r11_exp_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> $stable(exp_q));

endmodule

// File: rtl/seu_report_core.sv
module seu_report_core
   import seu_rpt_pkg::*;
#(
   parameter int MSG_W      = 46,
   parameter int QUIET_TICKS = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             det_ce,
   input  logic             rpt_valid,
   input  logic [MSG_W-1:0] rpt_data,
   output logic [MSG_W-1:0] msg_q,
   output logic             msg_new,
   output logic             err_flag
);
   localparam int QW = $clog2(QUIET_TICKS);

   generate
      if (QUIET_TICKS < 2) begin : g_bad_quiet
         $error("seu_report_core: QUIET_TICKS must be at least 2");
      end
      if (MSG_W < 1) begin : g_bad_w
         $error("seu_report_core: MSG_W must be positive");
      end
   endgenerate

   flag_state_t st_q;
   logic [QW-1:0] quiet_q;
   logic pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         msg_q   <= '0;
         msg_new <= 1'b0;
      end else begin
         msg_new <= rpt_valid;
         if (rpt_valid) msg_q <= rpt_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= FL_IDLE;
         quiet_q <= '0;
         pend_q  <= 1'b0;
      end else begin
         case (st_q)
            FL_IDLE: begin
               if (pend_q) begin
                  st_q   <= FL_HIGH;
                  pend_q <= rpt_valid;
               end else begin
                  pend_q <= rpt_valid;
               end
            end
            FL_HIGH: begin
               if (rpt_valid) pend_q <= 1'b1;
               if (det_ce) begin
                  st_q    <= FL_QUIET;
                  quiet_q <= '0;
               end
            end
            FL_QUIET: begin
               if (rpt_valid) pend_q <= 1'b1;
               if (det_ce) begin
                  if (quiet_q == QW'(QUIET_TICKS - 1)) st_q <= FL_IDLE;
                  else quiet_q <= quiet_q + 1'b1;
               end
            end
            default: st_q <= FL_IDLE;
         endcase
      end
   end

   assign err_flag = (st_q == FL_HIGH);

   // ---- checking logic ----
   logic flag_d;
   logic fresh_q;
   logic [QW:0] low_ticks;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_d    <= 1'b0;
         fresh_q   <= 1'b0;
         low_ticks <= (QW+1)'(QUIET_TICKS);
      end else begin
         flag_d <= err_flag;
         if (err_flag && !flag_d) fresh_q <= msg_new;
         else if (msg_new) fresh_q <= 1'b1;
         if (flag_d && !err_flag) low_ticks <= '0;
         else if (!err_flag && det_ce && low_ticks < (QW+1)'(QUIET_TICKS))
            low_ticks <= low_ticks + 1'b1;
      end
   end

   // R1: message register follows every valid report
   a_r1_msg_load: assert property (@(posedge clk) disable iff (!rst_n)
      rpt_valid |=> msg_q == $past(rpt_data));

   // R2: every rise is backed by a report stored since the previous rise
   a_r2_rise_fresh: assert property (@(posedge clk) disable iff (!rst_n)
      (err_flag && !flag_d) |-> fresh_q);

   // R3: quiet interval honoured before each rise
   a_r3_quiet_len: assert property (@(posedge clk) disable iff (!rst_n)
      (err_flag && !flag_d) |-> low_ticks >= (QW+1)'(QUIET_TICKS));

   // R3: flag drops only on a detection tick
   a_r3_high_until_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (err_flag && !det_ce) |=> err_flag);

endmodule

// File: rtl/seu_readout_path.sv
module seu_readout_path #(
   parameter int MSG_W = 46
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [MSG_W-1:0] msg_q,
   input  logic             msg_new,
   input  logic             snap_en,
   input  logic             cap,
   input  logic             shift,
   input  logic             sin,
   output logic             sout,
   output logic             overrun
);
   generate
      if (MSG_W < 2) begin : g_bad_w
         $error("seu_readout_path: MSG_W must be at least 2");
      end
   endgenerate

   logic [MSG_W-1:0] upd_q;
   logic [MSG_W-1:0] sr_q;
   logic stale_q;
   logic copy;

   assign copy = snap_en && (msg_new || stale_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         upd_q   <= '0;
         stale_q <= 1'b0;
         overrun <= 1'b0;
      end else begin
         if (copy) upd_q <= msg_q;
         stale_q <= !snap_en && (msg_new || stale_q);
         if (msg_new && !snap_en) overrun <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sr_q <= '0;
      end else if (cap) begin
         sr_q <= upd_q;
      end else if (shift) begin
         sr_q <= {sin, sr_q[MSG_W-1:1]};
      end
   end

   assign sout = sr_q[0];

   // R5: copy one edge after the report lands
   a_r5_copy: assert property (@(posedge clk) disable iff (!rst_n)
      (snap_en && msg_new) |=> upd_q == $past(msg_q));

   // R6: frozen snapshot while enable is low
   a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !snap_en |=> $stable(upd_q));

   // R7: overrun is sticky
   a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> overrun);

   // R8: capture loads the snapshot
   a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
      cap |=> sr_q == $past(upd_q));

   // R9: serial input lands in the MSB
   a_r9_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
      (shift && !cap) |=> sr_q[MSG_W-1] == $past(sin));

endmodule

// File: rtl/seu_report_capture.sv
module seu_report_capture #(
   parameter int MSG_W       = 46,
   parameter int N_READERS   = 2,
   parameter int QUIET_TICKS = 32,
   parameter int SEL_W       = 4,
   parameter int EXP_MAX     = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [SEL_W-1:0]     div_sel,
   output logic                 det_ce,
   input  logic                 rpt_valid,
   input  logic [MSG_W-1:0]     rpt_data,
   output logic                 err_flag,
   input  logic [N_READERS-1:0] snap_en,
   input  logic [N_READERS-1:0] cap,
   input  logic [N_READERS-1:0] shift,
   input  logic [N_READERS-1:0] sin,
   output logic [N_READERS-1:0] sout,
   output logic [N_READERS-1:0] overrun
);
   generate
      if (N_READERS < 1) begin : g_bad_n
         $error("seu_report_capture: need at least one reader");
      end
   endgenerate

   logic [MSG_W-1:0] msg_q;
   logic msg_new;

   seu_det_ce_gen #(
      .SEL_W  (SEL_W),
      .EXP_MAX(EXP_MAX)
   ) u_ce (
      .clk    (clk),
      .rst_n  (rst_n),
      .div_sel(div_sel),
      .det_ce (det_ce)
   );

   seu_report_core #(
      .MSG_W      (MSG_W),
      .QUIET_TICKS(QUIET_TICKS)
   ) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .det_ce   (det_ce),
      .rpt_valid(rpt_valid),
      .rpt_data (rpt_data),
      .msg_q    (msg_q),
      .msg_new  (msg_new),
      .err_flag (err_flag)
   );

   generate
      for (genvar g = 0; g < N_READERS; g++) begin : g_path
         seu_readout_path #(
            .MSG_W(MSG_W)
         ) u_path (
            .clk    (clk),
            .rst_n  (rst_n),
            .msg_q  (msg_q),
            .msg_new(msg_new),
            .snap_en(snap_en[g]),
            .cap    (cap[g]),
            .shift  (shift[g]),
            .sin    (sin[g]),
            .sout   (sout[g]),
            .overrun(overrun[g])
         );
      end
   endgenerate

endmodule

// File: tb/seu_report_capture_bench.sv
module seu_report_capture_bench;
   localparam int W = 46;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [3:0] div_sel = 4'd1;
   logic det_ce;
   logic rpt_valid = 1'b0;
   logic [W-1:0] rpt_data = '0;
   logic err_flag;
   logic [1:0] snap_en = 2'b11;
   logic [1:0] cap = 2'b00;
   logic [1:0] shift = 2'b00;
   logic [1:0] sin = 2'b00;
   logic [1:0] sout;
   logic [1:0] overrun;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   localparam logic [W-1:0] RA = 46'h2A5F_0C31_7E9D;
   localparam logic [W-1:0] RB = 46'h1111_2222_3333;
   localparam logic [W-1:0] RC = 46'h3C0F_F00F_A55A;
   localparam logic [W-1:0] RD = 46'h0BAD_CAFE_1234;
   localparam logic [W-1:0] SP = 46'h2DB6_DB6D_B6DB;

   always #4 clk = ~clk;

   seu_report_capture u_seu_report_capture (
      .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .det_ce(det_ce),
      .rpt_valid(rpt_valid), .rpt_data(rpt_data), .err_flag(err_flag),
      .snap_en(snap_en), .cap(cap), .shift(shift), .sin(sin),
      .sout(sout), .overrun(overrun)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp_v);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
      end
   endtask

   task automatic do_reset(input logic [3:0] sel);
      @(negedge clk);
      rst_n = 1'b0;
      div_sel = sel;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic send(input logic [W-1:0] d);
      @(negedge clk);
      rpt_valid = 1'b1;
      rpt_data = d;
      @(negedge clk);
      rpt_valid = 1'b0;
   endtask

   task automatic shift_out(input int idx, input logic [W-1:0] pat,
                            output logic [W-1:0] v);
      for (int i = 0; i < W; i++) begin
         v[i] = sout[idx];
         sin[idx] = pat[i];
         shift[idx] = 1'b1;
         @(negedge clk);
      end
      shift[idx] = 1'b0;
   endtask

   task automatic unload(input int idx, input logic [W-1:0] pat,
                         output logic [W-1:0] v);
      cap[idx] = 1'b1;
      @(negedge clk);
      cap[idx] = 1'b0;
      shift_out(idx, pat, v);
   endtask

   task automatic measure_period(output int per);
      int guard = 0;
      while (!det_ce && guard < 1000) begin @(negedge clk); guard++; end
      per = 0;
      @(negedge clk); per = 1;
      while (!det_ce && per < 1000) begin @(negedge clk); per++; end
   endtask

   task automatic t_reset_state();
      chk(err_flag == 1'b0, "R3 flag low after reset", 64'(err_flag), 0);
      chk(overrun == 2'b00, "R7 overrun clear after reset", 64'(overrun), 0);
      chk(sout == 2'b00, "R9 sout zero after reset", 64'(sout), 0);
   endtask

   task automatic t_basic_report();
      logic [W-1:0] v;
      send(RA);
      chk(err_flag == 1'b0, "R2 flag still low one edge after valid", 64'(err_flag), 0);
      @(negedge clk);
      chk(err_flag == 1'b1, "R2 flag high two edges after valid", 64'(err_flag), 1);
      unload(0, '0, v);
      chk(v == RA, "R5 R8 test-port path unload", 64'(v), 64'(RA));
      unload(1, '0, v);
      chk(v == RA, "R10 core path unload", 64'(v), 64'(RA));
      chk(overrun == 2'b00, "R7 no overrun with enables high", 64'(overrun), 0);
   endtask

   task automatic t_quiet_and_pending();
      int ticks = 0;
      int g = 0;
      int rises = 0;
      logic prev;
      logic [W-1:0] v;
      while (err_flag && g < 100) begin @(negedge clk); g++; end
      send(RB);
      if (det_ce && !err_flag) ticks++;
      send(RC);
      if (det_ce && !err_flag) ticks++;
      g = 0;
      while (!err_flag && g < 2000) begin
         if (det_ce) ticks++;
         @(negedge clk);
         g++;
      end
      chk(err_flag == 1'b1, "R4 flag rises after quiet interval", 64'(err_flag), 1);
      chk(ticks >= 32, "R3 quiet interval length in ticks", 64'(ticks), 32);
      prev = err_flag;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (err_flag && !prev) rises++;
         prev = err_flag;
      end
      chk(rises == 0, "R4 two pending reports give one rise", 64'(rises), 0);
      unload(0, '0, v);
      chk(v == RC, "R1 R4 message holds latest report", 64'(v), 64'(RC));
   endtask

   task automatic t_deferred_copy();
      logic [W-1:0] v;
      snap_en[1] = 1'b0;
      send(RD);
      repeat (3) @(negedge clk);
      unload(1, '0, v);
      chk(v == RC, "R6 frozen snapshot keeps old report", 64'(v), 64'(RC));
      chk(overrun[1] == 1'b1, "R7 overrun set on frozen path", 64'(overrun[1]), 1);
      chk(overrun[0] == 1'b0, "R10 other path overrun untouched", 64'(overrun[0]), 0);
      unload(0, '0, v);
      chk(v == RD, "R10 enabled path gets new report", 64'(v), 64'(RD));
      snap_en[1] = 1'b1;
      @(negedge clk);
      unload(1, '0, v);
      chk(v == RD, "R6 copy on first enabled edge", 64'(v), 64'(RD));
      chk(overrun[1] == 1'b1, "R7 overrun stays set", 64'(overrun[1]), 1);
   endtask

   task automatic t_serial();
      logic [W-1:0] v;
      unload(0, SP, v);
      chk(v == RD, "R9 LSB-first unload", 64'(v), 64'(RD));
      shift_out(0, '0, v);
      chk(v == SP, "R9 serial input fills from MSB", 64'(v), 64'(SP));
      cap[0] = 1'b1;
      shift[0] = 1'b1;
      sin[0] = 1'b1;
      @(negedge clk);
      cap[0] = 1'b0;
      shift[0] = 1'b0;
      shift_out(0, '0, v);
      chk(v == RD, "R8 capture wins over shift", 64'(v), 64'(RD));
   endtask

   task automatic t_divider();
      int per;
      do_reset(4'd1);
      measure_period(per);
      chk(per == 2, "R11 period for n=1", 64'(per), 2);
      do_reset(4'd3);
      div_sel = 4'd5;
      measure_period(per);
      chk(per == 8, "R11 n=3 and later change ignored", 64'(per), 8);
      do_reset(4'd0);
      measure_period(per);
      chk(per == 256, "R11 n=0 clamps to 8", 64'(per), 256);
      do_reset(4'd12);
      measure_period(per);
      chk(per == 256, "R11 n=12 clamps to 8", 64'(per), 256);
      chk(overrun == 2'b00, "R7 reset clears overrun", 64'(overrun), 0);
   endtask

   initial begin
      do_reset(4'd1);
      @(negedge clk);
      t_reset_state();
      t_basic_report();
      t_quiet_and_pending();
      t_deferred_copy();
      t_serial();
      t_divider();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog all requirements actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule